// File: doc/BRIEF.md
# Interlaced Monochrome Video Mode Extension

This block extends a character/graphics video adapter with a doubled-vertical-resolution monochrome mode. It sits on the host's 8-bit I/O bus in front of the CRTC register file. It remembers which CRTC register the host selected, and it rescales certain register values on their way in. This lets software written for a 200-line timing drive a 400-line raster. The block also holds one extra mode register and answers a status read that reports the sync flags.

When the high-resolution bit of the mode register is set, the block generates video-memory byte addresses itself. The two low bits of the CRTC row address pick one of four interleaved 8 KB banks in a 32 KB memory. Two bytes are fetched for each character cell and shifted out most significant bit first, so each cell gives 16 pixels in the foreground colour. When the bit is clear, the standard adapter path is used: the block hands it a row address halved by one bit, so every scanline is shown twice. The CRTC timing generator and the memory array are outside the block.

Top module: `hires_mono_ext`

## Requirements
- R1: An I/O write to offset 0, 2, 4 or 6 pulses `crtc_addr_we` in the same cycle, with `crtc_wdata` equal to the written byte, and latches that byte as the register index. A write to any offset of 8 or above pulses neither CRTC strobe.
- R2: An I/O write to offset 1, 3, 5 or 7 pulses `crtc_data_we`. The data is translated according to the low 5 bits of the latched index. Index 0 clears bit 7. Every index other than 0, 9, 10 and 11 passes the byte unchanged.
- R3: For index 9, a byte d below 0x80 and not equal to 3 is sent as 2*d+1. Any other byte is sent unchanged.
- R4: For index 10, the byte sent is ((d<<1) & 0x1F) | (d & 0x60). For index 11, the byte sent is d<<1, truncated to 8 bits.
- R5: A write to offset 0x0E loads the 8-bit mode register. A read from offset 0x0E returns it and raises `io_rhit`. Writes to other offsets leave it unchanged.
- R6: A read from offset 0x0A returns a status byte and raises `io_rhit`. Bits 7, 6 and 2 of the byte are 1, bit 3 is `vsync`, bit 0 is `hsync`, and all other bits are 0. Reads from offsets other than 0x0A and 0x0E leave `io_rhit` low.
- R7: `std_ra` equals `ra` shifted right by one when mode bit 0 is clear, and equals `ra` when mode bit 0 is set.
- R8: After a `line_go` pulse, cell c (0 to cell_cnt-1) is fetched at byte address (((ma+c)<<1) & 0x1FFF) | ((ra&3)<<13), plus the start offset, taken modulo 32768. The address of the cell's first byte is shown in cycle 16c+1 after the pulse and the address of its second byte (the first plus one) in cycle 16c+2. Memory data arrives one cycle after its address.
- R9: The start offset is 0x4000 when mode bit 3 is 1 and bit 0 is 0. Otherwise it is 0.
- R10: For each fetched cell, `pix_valid` is high for 16 consecutive cycles, exactly 16*cell_cnt cycles per line. Pixels leave the first byte, then the second, most significant bit first. A 1 bit shows `color_sel` and a 0 bit shows 0.
- R11: `pix` is 0 whenever `de` is low or mode bit 0 is clear.
- R12: Reset clears the mode register and leaves both CRTC strobes and `pix_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 4 | I/O offset within the adapter window |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, valid when io_rhit |
| io_rhit | output | 1 | Read was claimed by this block |
| crtc_addr_we | output | 1 | CRTC index port write strobe |
| crtc_data_we | output | 1 | CRTC data port write strobe |
| crtc_wdata | output | 8 | Data for the CRTC port |
| vsync | input | 1 | Vertical sync flag |
| hsync | input | 1 | Horizontal sync flag |
| color_sel | input | 4 | Foreground colour |
| line_go | input | 1 | Start of a scanline's cell run |
| ma | input | 14 | CRTC memory address at line start |
| ra | input | 5 | CRTC row address |
| cell_cnt | input | 7 | Character cells on the line |
| de | input | 1 | Display enable |
| std_ra | output | 5 | Row address handed to the standard path |
| vram_addr | output | 15 | Video memory byte address |
| vram_rdata | input | 8 | Video memory data, one cycle after address |
| pix_valid | output | 1 | Pixel slot is occupied |
| pix | output | 4 | Pixel colour index |

## Verification
The assertions assume that I/O strobes come one at a time and never during a line's cell run. They also assume that `line_go` is a single-cycle pulse followed by at least 16*cell_cnt+4 quiet cycles, so the fetch window is never restarted mid-cell. The bench follows these rules. Every register access is a separate one-cycle strobe, and mode changes are made only between lines. Each line is run to completion, with margin, before the next `line_go`. The memory model answers each address from an arithmetic function of the address, registered one cycle late, which matches the read latency the fetch schedule expects.

// File: rtl/hme_pkg.sv
package hme_pkg;
   localparam logic [3:0] MODE_OFS = 4'hE;
   localparam logic [3:0] STAT_OFS = 4'hA;
   localparam int CELL_BITS = 16;

   typedef enum logic [1:0] {
      XL_PASS,
      XL_MASK7,
      XL_LINEDBL,
      XL_CURSOR
   } xl_kind_t;

   function automatic logic [7:0] rescale(input logic [4:0] idx, input logic [7:0] d);
      logic [7:0] r;
      r = d;
      unique case (idx)
         5'd0:  r = {1'b0, d[6:0]};
         5'd9:  r = (d < 8'h80 && d != 8'h03) ? {d[6:0], 1'b1} : d;
         5'd10: r = {1'b0, d[6:5], d[3:0], 1'b0};
         5'd11: r = {d[6:0], 1'b0};
         default: r = d;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/hme_crtc_port.sv
module hme_crtc_port import hme_pkg::*; #(
   parameter int IO_AW = 4,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             io_wr,
   input  logic [IO_AW-1:0] io_addr,
   input  logic [7:0]       io_wdata,
   output logic             crtc_addr_we,
   output logic             crtc_data_we,
   output logic [7:0]       crtc_wdata
);
   localparam int WIN_LSB = 3;

   logic       in_win;
   logic [7:0] idx_q;

   generate
      if (IO_AW > WIN_LSB) begin : g_wide
         assign in_win = (io_addr[IO_AW-1:WIN_LSB] == '0);
      end else begin : g_narrow
         assign in_win = 1'b1;
      end
   endgenerate

   assign crtc_addr_we = io_wr && in_win && !io_addr[0];
   assign crtc_data_we = io_wr && in_win && io_addr[0];

   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= '0;
      else if (crtc_addr_we) idx_q <= io_wdata;
   end

   always_comb begin
      if (crtc_data_we) crtc_wdata = rescale(idx_q[IDX_W-1:0], io_wdata);
      else crtc_wdata = io_wdata;
   end
endmodule

// File: rtl/hme_mode_regs.sv
module hme_mode_regs import hme_pkg::*; #(
   parameter int IO_AW   = 4,
   parameter int VRAM_AW = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [IO_AW-1:0]   io_addr,
   input  logic [7:0]         io_wdata,
   input  logic               vsync,
   input  logic               hsync,
   output logic [7:0]         mode_q,
   output logic [VRAM_AW-1:0] start_off,
   output logic [7:0]         io_rdata,
   output logic               io_rhit
);
   localparam logic [VRAM_AW-1:0] HALF_OFS = VRAM_AW'(1) << (VRAM_AW - 1);

   logic sel_mode, sel_stat;

   assign sel_mode = (io_addr == IO_AW'(MODE_OFS));
   assign sel_stat = (io_addr == IO_AW'(STAT_OFS));

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= '0;
      else if (io_wr && sel_mode) mode_q <= io_wdata;
   end

   assign start_off = (mode_q[3] && !mode_q[0]) ? HALF_OFS : '0;

   always_comb begin
      io_rhit  = io_rd && (sel_mode || sel_stat);
      io_rdata = 8'hFF;
      if (sel_mode) io_rdata = mode_q;
      else if (sel_stat) io_rdata = {2'b11, 2'b00, vsync, 1'b1, 1'b0, hsync};
   end
endmodule

// File: rtl/hme_fetch.sv
module hme_fetch #(
   parameter int MA_W    = 14,
   parameter int RA_W    = 5,
   parameter int CNT_W   = 7,
   parameter int VRAM_AW = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_go,
   input  logic [MA_W-1:0]    ma,
   input  logic [RA_W-1:0]    ra,
   input  logic [CNT_W-1:0]   cell_cnt,
   input  logic [VRAM_AW-1:0] start_off,
   output logic [VRAM_AW-1:0] vram_addr,
   output logic               ld_first,
   output logic               ld_cell,
   output logic               cell_ok
);
   localparam int BANK_W = VRAM_AW - 2;
   localparam int MA_USE = BANK_W - 1;
   localparam logic [3:0] PH_FIRST = 4'd14;
   localparam logic [3:0] PH_SECOND = 4'd15;
   localparam logic [3:0] PH_LOAD = 4'd0;

   logic              run;
   logic [3:0]        phase;
   logic [CNT_W-1:0]  fcell, cnt_q;
   logic [MA_W-1:0]   ma_q, cell_ma;
   logic [1:0]        bank_q;
   logic              fetching;
   logic [VRAM_AW-1:0] base;

   assign fetching = run && (fcell < cnt_q);
   assign cell_ma  = ma_q + MA_W'(fcell);
   assign base     = {bank_q, cell_ma[MA_USE-1:0], 1'b0} + start_off;
   assign vram_addr = base | VRAM_AW'(phase == PH_SECOND);

   assign ld_first = run && (phase == PH_SECOND);
   assign ld_cell  = run && (phase == PH_LOAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run     <= 1'b0;
         phase   <= '0;
         fcell   <= '0;
         cnt_q   <= '0;
         ma_q    <= '0;
         bank_q  <= '0;
         cell_ok <= 1'b0;
      end else if (line_go) begin
         run     <= 1'b1;
         phase   <= PH_FIRST;
         fcell   <= '0;
         cnt_q   <= cell_cnt;
         ma_q    <= ma;
         bank_q  <= ra[1:0];
         cell_ok <= 1'b0;
      end else if (run) begin
         phase <= phase + 4'd1;
         if (phase == PH_SECOND) begin
            cell_ok <= fetching;
            if (fetching) fcell <= fcell + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/hme_shifter.sv
module hme_shifter import hme_pkg::*; #(
   parameter int COL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_go,
   input  logic             ld_first,
   input  logic             ld_cell,
   input  logic             cell_ok,
   input  logic [7:0]       vram_rdata,
   input  logic             hires,
   input  logic             de,
   input  logic [COL_W-1:0] color_sel,
   output logic             pix_valid,
   output logic [COL_W-1:0] pix
);
   logic [7:0]           first_q;
   logic [CELL_BITS-1:0] sh_q;
   logic                 lit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q   <= '0;
         sh_q      <= '0;
         pix_valid <= 1'b0;
      end else begin
         if (ld_first) first_q <= vram_rdata;
         if (line_go) begin
            pix_valid <= 1'b0;
         end else if (ld_cell) begin
            sh_q      <= {first_q, vram_rdata};
            pix_valid <= cell_ok;
         end else begin
            sh_q <= {sh_q[CELL_BITS-2:0], 1'b0};
         end
      end
   end

   assign lit = pix_valid && de && hires && sh_q[CELL_BITS-1];

   generate
      for (genvar b = 0; b < COL_W; b++) begin : g_col
         assign pix[b] = lit & color_sel[b];
      end
   endgenerate
endmodule

// File: rtl/hires_mono_ext.sv
module hires_mono_ext #(
   parameter int IO_AW   = 4,
   parameter int MA_W    = 14,
   parameter int RA_W    = 5,
   parameter int CNT_W   = 7,
   parameter int COL_W   = 4,
   parameter int VRAM_AW = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [IO_AW-1:0]   io_addr,
   input  logic [7:0]         io_wdata,
   output logic [7:0]         io_rdata,
   output logic               io_rhit,
   output logic               crtc_addr_we,
   output logic               crtc_data_we,
   output logic [7:0]         crtc_wdata,
   input  logic               vsync,
   input  logic               hsync,
   input  logic [COL_W-1:0]   color_sel,
   input  logic               line_go,
   input  logic [MA_W-1:0]    ma,
   input  logic [RA_W-1:0]    ra,
   input  logic [CNT_W-1:0]   cell_cnt,
   input  logic               de,
   output logic [RA_W-1:0]    std_ra,
   output logic [VRAM_AW-1:0] vram_addr,
   input  logic [7:0]         vram_rdata,
   output logic               pix_valid,
   output logic [COL_W-1:0]   pix
);
   generate
      if (VRAM_AW != 15) begin : g_bad_vram
         $error("hires_mono_ext: four 8 KB banks need VRAM_AW of 15");
      end
      if (MA_W < VRAM_AW - 3) begin : g_bad_ma
         $error("hires_mono_ext: MA_W too narrow for a bank");
      end
      if (IO_AW < 4) begin : g_bad_io
         $error("hires_mono_ext: IO_AW must reach offset 0x0E");
      end
      if (RA_W < 2 || COL_W < 1 || CNT_W < 1) begin : g_bad_misc
         $error("hires_mono_ext: RA_W, COL_W or CNT_W out of range");
      end
   endgenerate

   logic [7:0]         mode_q;
   logic [VRAM_AW-1:0] start_off;
   logic               ld_first, ld_cell, cell_ok;
   logic               hires;

   assign hires  = mode_q[0];
   assign std_ra = hires ? ra : (ra >> 1);

   hme_crtc_port #(.IO_AW(IO_AW), .IDX_W(5)) u_port (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
      .crtc_addr_we(crtc_addr_we), .crtc_data_we(crtc_data_we), .crtc_wdata(crtc_wdata)
   );

   hme_mode_regs #(.IO_AW(IO_AW), .VRAM_AW(VRAM_AW)) u_mode (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
      .io_wdata(io_wdata), .vsync(vsync), .hsync(hsync), .mode_q(mode_q),
      .start_off(start_off), .io_rdata(io_rdata), .io_rhit(io_rhit)
   );

   hme_fetch #(.MA_W(MA_W), .RA_W(RA_W), .CNT_W(CNT_W), .VRAM_AW(VRAM_AW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .line_go(line_go), .ma(ma), .ra(ra), .cell_cnt(cell_cnt),
      .start_off(start_off), .vram_addr(vram_addr), .ld_first(ld_first),
      .ld_cell(ld_cell), .cell_ok(cell_ok)
   );

   hme_shifter #(.COL_W(COL_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .line_go(line_go), .ld_first(ld_first), .ld_cell(ld_cell),
      .cell_ok(cell_ok), .vram_rdata(vram_rdata), .hires(hires), .de(de),
      .color_sel(color_sel), .pix_valid(pix_valid), .pix(pix)
   );
endmodule

// File: rtl/hires_mono_ext_chk.sv
module hires_mono_ext_chk #(
   parameter int IO_AW = 4,
   parameter int COL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             io_wr,
   input logic             io_rd,
   input logic [IO_AW-1:0] io_addr,
   input logic [7:0]       io_rdata,
   input logic             io_rhit,
   input logic             crtc_addr_we,
   input logic             crtc_data_we,
   input logic [7:0]       mode_q,
   input logic             de,
   input logic             pix_valid,
   input logic [COL_W-1:0] pix,
   input logic [COL_W-1:0] color_sel
);
   // R1
   idx_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crtc_addr_we |-> (io_wr && !io_addr[0] && io_addr < IO_AW'(8)));

   // R2
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({crtc_addr_we, crtc_data_we}));

   // R5
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == IO_AW'(14)) |=> $stable(mode_q));

   // R6
   status_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == IO_AW'(10)) |-> (io_rhit && io_rdata[7:6] == 2'b11 && io_rdata[2]));

   // R11
   pix_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix != '0) |-> (pix_valid && de && mode_q[0] && pix == color_sel));
endmodule

bind hires_mono_ext hires_mono_ext_chk #(.IO_AW(IO_AW), .COL_W(COL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
   .io_rdata(io_rdata), .io_rhit(io_rhit), .crtc_addr_we(crtc_addr_we),
   .crtc_data_we(crtc_data_we), .mode_q(mode_q), .de(de), .pix_valid(pix_valid),
   .pix(pix), .color_sel(color_sel)
);

// File: tb/hires_mono_ext_test.sv
module hires_mono_ext_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [3:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_rhit, crtc_addr_we, crtc_data_we;
   logic [7:0]  crtc_wdata;
   logic        vsync = 1'b0, hsync = 1'b0;
   logic [3:0]  color_sel = 4'hB;
   logic        line_go = 1'b0;
   logic [13:0] ma = '0;
   logic [4:0]  ra = '0;
   logic [6:0]  cell_cnt = '0;
   logic        de = 1'b1;
   logic [4:0]  std_ra;
   logic [14:0] vram_addr;
   logic [7:0]  vram_rdata = '0;
   logic [14:0] addr_seen = '0;
   logic        pix_valid;
   logic [3:0]  pix;

   int nvec = 0, nfail = 0, cyc = 0;
   logic [3:0] got [0:511];
   int ngot;

   hires_mono_ext uut (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rhit(io_rhit),
      .crtc_addr_we(crtc_addr_we), .crtc_data_we(crtc_data_we), .crtc_wdata(crtc_wdata),
      .vsync(vsync), .hsync(hsync), .color_sel(color_sel), .line_go(line_go), .ma(ma),
      .ra(ra), .cell_cnt(cell_cnt), .de(de), .std_ra(std_ra), .vram_addr(vram_addr),
      .vram_rdata(vram_rdata), .pix_valid(pix_valid), .pix(pix)
   );

   always #10 clk = ~clk;

   function automatic int memval(int a);
      return ((a * 13) ^ (a >> 7)) & 255;
   endfunction

   always @(negedge clk) addr_seen <= vram_addr;
   always @(posedge clk) vram_rdata <= 8'(memval(int'(addr_seen)));

   task automatic chk(string req, int act, int exp);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int xl(int idx, int d);
      if (idx == 0) return d & 127;
      if (idx == 9) return (d < 128 && d != 3) ? ((2 * d + 1) & 255) : d;
      if (idx == 10) return ((d * 2) & 31) | (d & 96);
      if (idx == 11) return (d * 2) & 255;
      return d;
   endfunction

   function automatic int exp_addr(int m, int c, int r, int md, int b);
      int a, so;
      a = ((((m + c) & 16383) * 2) & 8191) | ((r & 3) << 13);
      so = ((md & 8) != 0 && (md & 1) == 0) ? 16384 : 0;
      return ((a + so) & 32767) + b;
   endfunction

   task automatic wr(int a, int d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = 4'(a); io_wdata = 8'(d);
      #5;
   endtask

   task automatic wr_end();
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(int a, output int data, output int hit);
      @(negedge clk);
      io_rd = 1'b1; io_addr = 4'(a);
      #5;
      data = int'(io_rdata); hit = int'(io_rhit);
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic run_line(int m, int r, int n, int md, int de_v);
      int k, c, j, word, bit_v, e;
      @(negedge clk);
      line_go = 1'b1; ma = 14'(m); ra = 5'(r); cell_cnt = 7'(n); de = de_v[0];
      ngot = 0;
      @(negedge clk);
      line_go = 1'b0;
      chk("R7 std_ra", int'(std_ra), (md & 1) ? r : (r >> 1));
      for (k = 0; k < 16 * n + 24; k++) begin
         if ((k / 16) < n && (k % 16) < 2)
            chk("R8/R9 vram_addr", int'(vram_addr), exp_addr(m, k / 16, r, md, k % 16));
         if (pix_valid && ngot < 512) begin
            got[ngot] = pix;
            ngot++;
         end
         @(negedge clk);
      end
      chk("R10 pixel count", ngot, 16 * n);
      for (int p = 0; p < ngot; p++) begin
         c = p / 16; j = p % 16;
         word = (memval(exp_addr(m, c, r, md, 0)) << 8) | memval(exp_addr(m, c, r, md, 1));
         bit_v = (word >> (15 - j)) & 1;
         e = (bit_v == 1 && (md & 1) == 1 && de_v == 1) ? int'(color_sel) : 0;
         chk((md & 1) && de_v ? "R10 pixel" : "R11 pixel", int'(got[p]), e);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog (R10) actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
         end
      end
   end

   initial begin
      int data, hit, exp_v;
      int datas [8] = '{0, 3, 5, 127, 128, 255, 165, 60};
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 addr_we in reset", int'(crtc_addr_we), 0);
      chk("R12 pix_valid in reset", int'(pix_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(14, data, hit);
      chk("R12 mode after reset", data, 0);
      chk("R5 mode read hit", hit, 1);

      // R1..R4 sweep over every index and several data bytes
      for (int idx = 0; idx < 32; idx++) begin
         for (int q = 0; q < 8; q++) begin
            wr((idx % 4) * 2, idx + 32 * q);
            chk("R1 addr strobe", int'(crtc_addr_we), 1);
            chk("R1 data strobe low", int'(crtc_data_we), 0);
            chk("R1 index passthrough", int'(crtc_wdata), (idx + 32 * q) & 255);
            wr_end();
            wr((q % 4) * 2 + 1, datas[q]);
            chk("R2 data strobe", int'(crtc_data_we), 1);
            if (idx == 9) chk("R3 rescale", int'(crtc_wdata), xl(idx, datas[q]));
            else if (idx == 10 || idx == 11) chk("R4 rescale", int'(crtc_wdata), xl(idx, datas[q]));
            else chk("R2 rescale", int'(crtc_wdata), xl(idx, datas[q]));
            wr_end();
         end
      end

      // R1 writes above the window reach no CRTC port, R5 leave mode alone
      for (int a = 8; a < 16; a++) begin
         if (a != 14) begin
            wr(a, 8'h5A);
            chk("R1 no strobe outside window", int'(crtc_addr_we | crtc_data_we), 0);
            wr_end();
         end
      end
      rd(14, data, hit);
      chk("R5 mode untouched", data, 0);

      // R6 status for all sync combinations, and unclaimed reads
      for (int s = 0; s < 4; s++) begin
         vsync = s[1]; hsync = s[0];
         rd(10, data, hit);
         exp_v = 8'hC4 | (s[1] << 3) | s[0];
         chk("R6 status byte", data, exp_v);
         chk("R6 status hit", hit, 1);
      end
      rd(12, data, hit);
      chk("R6 no hit elsewhere", hit, 0);

      // R5 mode write/readback
      wr(14, 8'h6D); wr_end();
      rd(14, data, hit);
      chk("R5 mode readback", data, 8'h6D);

      // R7..R11 lines across all four banks and mode variants
      foreach (datas[q]) begin end
      for (int mv = 0; mv < 3; mv++) begin
         int md;
         md = (mv == 0) ? 8'h01 : (mv == 1) ? 8'h09 : 8'h08;
         wr(14, md); wr_end();
         for (int r = 0; r < 4; r++) begin
            run_line(14'h0000 + r * 40, r + 4 * (r % 2), 3, md, 1);
            run_line(14'h0FFE, r, 3, md, 1);
         end
      end
      // R11 display enable low in high-resolution mode
      wr(14, 8'h01); wr_end();
      run_line(14'h0123, 2, 2, 1, 0);
      // R10 zero cells gives no pixels
      run_line(14'h0010, 1, 0, 1, 1);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule